// File: doc/BRIEF.md
# Ethernet Transmit Frame Finisher

This block sits on the transmit byte path just before line coding. A source hands it one frame at a time as a byte stream on a valid/ready handshake, with a flag on the first byte and another on the final byte. Payload bytes go straight through with no added latency. When the frame is shorter than the Ethernet minimum, the block fills it with zero bytes, and it can append the 32-bit frame check sequence (FCS). While it produces these extra bytes it holds the source off.

Two per-frame controls, "skip FCS" and "skip padding", are read only with the first byte of a frame. If padding is applied, the FCS is always appended, even when "skip FCS" was requested. The control is a three-state machine. `ST_DATA` passes payload bytes through. It moves to `ST_PAD` after the final payload byte when padding is needed, to `ST_FCS` when only the FCS is due, and otherwise stays in `ST_DATA`. `ST_PAD` emits zero bytes and moves to `ST_FCS` after the byte that brings the frame to 60 bytes. `ST_FCS` emits four FCS bytes and returns to `ST_DATA` after the fourth.

Top module: `tx_frame_finisher`

## Requirements
- R1: In the payload phase each input byte appears unchanged and in order on `m_data` in the same cycle, `m_valid` follows `s_valid` and `s_ready` follows `m_ready`.
- R2: When padding is allowed and the payload is shorter than 60 bytes, zero bytes follow the payload until 60 bytes have been sent, and the frame then ends with 4 FCS bytes, for 64 bytes in total. A payload of 60 bytes or more gets no pad.
- R3: Whenever pad bytes were inserted, the FCS is appended even if `cfg_no_fcs` was 1.
- R4: When `cfg_no_fcs` is 1 and no pad is inserted, the output frame is exactly the payload, and `m_last` is set on its final byte.
- R5: When `cfg_no_pad` is 1, a short payload is sent without pad bytes, followed by the FCS unless `cfg_no_fcs` is 1.
- R6: `cfg_no_fcs` and `cfg_no_pad` are taken only in the cycle the first byte (`s_first`=1) is accepted. Their values during later bytes of the frame have no effect.
- R7: The FCS is CRC-32 over payload and pad bytes. It uses the reflected form of polynomial 0x04C11DB7 (0xEDB88320 shifting right), starts from all ones and is complemented at the end. It is sent least significant byte first.
- R8: `s_ready` is 0 in every cycle in which a pad or FCS byte is presented.
- R9: `m_last` is set on exactly one byte per frame, the final one. After that byte the block is ready for the next frame's payload.
- R10: After reset `m_valid` is 0 while `s_valid` is 0, and the block is in the payload phase, with `s_ready` following `m_ready`.
- R11: A pad or FCS byte presented while `m_ready` is 0 stays on `m_data` and `m_last`, with `m_valid` held, until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Source byte valid |
| s_ready | output | 1 | Block accepts source byte |
| s_data | input | 8 | Source byte |
| s_first | input | 1 | Byte is the first of a frame |
| s_last | input | 1 | Byte is the final payload byte |
| cfg_no_fcs | input | 1 | Skip FCS for this frame (read with first byte) |
| cfg_no_pad | input | 1 | Skip padding for this frame (read with first byte) |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Sink accepts output byte |
| m_data | output | 8 | Output byte |
| m_last | output | 1 | Output byte ends the frame |

## Verification
Payload bytes are due on the output in the same cycle they are offered. The first pad or FCS byte is due in the cycle after the final payload byte is taken. Each later tail byte is due one cycle after the previous one is accepted, so a four-byte FCS after N pad bytes completes N+4 accepted cycles after the payload. The bench changes inputs just after a rising edge and samples every output at the falling edge. Only bytes with `m_valid` and `m_ready` both high at that sample are recorded, which makes the checks follow handshakes rather than fixed cycle counts even under sink back-pressure. For the same reason, the back-pressure hold check compares a stalled tail byte against its value one falling edge later.

// File: rtl/txfin_pkg.sv
package txfin_pkg;

    typedef enum logic [1:0] {
        ST_DATA = 2'd0,
        ST_PAD  = 2'd1,
        ST_FCS  = 2'd2
    } fin_state_e;

    // Right-shifting form of the Ethernet generator polynomial.
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;

endpackage

// File: rtl/txfin_crc_step.sv
module txfin_crc_step
    import txfin_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [31:0]   crc_in,
    input  logic [DW-1:0] din,
    output logic [31:0]   crc_out
);

    // One input word folded into the running remainder, LSB first.
    always_comb begin
        logic [31:0] c;
        c = crc_in;
        for (int i = 0; i < DW; i++) begin
            if (c[0] ^ din[i]) begin
                c = (c >> 1) ^ CRC_POLY_REFL;
            end else begin
                c = c >> 1;
            end
        end
        crc_out = c;
    end

endmodule

// File: rtl/txfin_beat_counter.sv
module txfin_beat_counter #(
    parameter int LIMIT = 60,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count
);

    // Saturates at LIMIT; clear has priority over increment.
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && (count < CW'(LIMIT))) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/tx_frame_finisher.sv
module tx_frame_finisher
    import txfin_pkg::*;
#(
    parameter int MIN_FRAME = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       s_valid,
    output logic       s_ready,
    input  logic [7:0] s_data,
    input  logic       s_first,
    input  logic       s_last,
    input  logic       cfg_no_fcs,
    input  logic       cfg_no_pad,
    output logic       m_valid,
    input  logic       m_ready,
    output logic [7:0] m_data,
    output logic       m_last
);

    localparam int FCS_BYTES  = 4;
    localparam int PAD_TARGET = MIN_FRAME - FCS_BYTES;
    localparam int CW         = $clog2(PAD_TARGET + 1);
    localparam logic [CW-1:0] PAD_LAST_IDX = CW'(PAD_TARGET - 1);

    fin_state_e  state_q, state_d;
    logic        no_fcs_q, no_pad_q;
    logic [1:0]  fcs_idx_q;
    logic [31:0] crc_q, crc_step_out, crc_seed, fcs_word, fcs_shift;
    logic [7:0]  crc_din;
    logic [CW-1:0] cnt;
    logic        cnt_inc, cnt_clr;
    logic        eff_no_fcs, eff_no_pad, pad_needed, fcs_on;
    logic        s_hs, data_hs, data_end, pad_beat, pad_done, fcs_done;

    // Controls count only when they arrive with the first byte.
    assign eff_no_fcs = s_first ? cfg_no_fcs : no_fcs_q;
    assign eff_no_pad = s_first ? cfg_no_pad : no_pad_q;

    assign s_hs     = s_valid && s_ready;
    assign data_hs  = (state_q == ST_DATA) && s_hs;
    assign data_end = data_hs && s_last;
    assign pad_beat = (state_q == ST_PAD) && m_ready;
    assign pad_done = pad_beat && (cnt == PAD_LAST_IDX);
    assign fcs_done = (state_q == ST_FCS) && m_ready && (fcs_idx_q == 2'd3);

    // Payload length on the final byte is cnt+1.
    assign pad_needed = !eff_no_pad && (cnt < PAD_LAST_IDX);
    assign fcs_on     = pad_needed || !eff_no_fcs;

    assign cnt_inc = data_hs || pad_beat;
    assign cnt_clr = (data_end && !pad_needed) || pad_done;

    txfin_beat_counter #(.LIMIT(PAD_TARGET)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (cnt)
    );

    assign crc_seed = ((state_q == ST_DATA) && s_first) ? CRC_SEED : crc_q;
    assign crc_din  = (state_q == ST_PAD) ? 8'h00 : s_data;

    txfin_crc_step #(.DW(8)) u_crc (
        .crc_in  (crc_seed),
        .din     (crc_din),
        .crc_out (crc_step_out)
    );

    assign fcs_word  = ~crc_q;
    assign fcs_shift = fcs_word >> {fcs_idx_q, 3'b000};

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DATA: begin
                if (data_end) begin
                    if (pad_needed)  state_d = ST_PAD;
                    else if (fcs_on) state_d = ST_FCS;
                end
            end
            ST_PAD:  if (pad_done) state_d = ST_FCS;
            ST_FCS:  if (fcs_done) state_d = ST_DATA;
            default: state_d = ST_DATA;
        endcase
    end

    // State register and datapath registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_DATA;
            no_fcs_q  <= 1'b0;
            no_pad_q  <= 1'b0;
            fcs_idx_q <= 2'd0;
            crc_q     <= CRC_SEED;
        end else begin
            state_q <= state_d;
            if (data_hs && s_first) begin
                no_fcs_q <= cfg_no_fcs;
                no_pad_q <= cfg_no_pad;
            end
            if (data_hs || pad_beat) begin
                crc_q <= crc_step_out;
            end else if (fcs_done) begin
                crc_q <= CRC_SEED;
            end
            if ((state_q == ST_FCS) && m_ready) begin
                fcs_idx_q <= fcs_idx_q + 2'd1;
            end
        end
    end

    // Output logic.
    always_comb begin
        m_valid = 1'b0;
        m_data  = 8'h00;
        m_last  = 1'b0;
        s_ready = 1'b0;
        unique case (state_q)
            ST_DATA: begin
                m_valid = s_valid;
                m_data  = s_data;
                m_last  = s_last && !fcs_on;
                s_ready = m_ready;
            end
            ST_PAD: begin
                m_valid = 1'b1;
            end
            ST_FCS: begin
                m_valid = 1'b1;
                m_data  = fcs_shift[7:0];
                m_last  = (fcs_idx_q == 2'd3);
            end
            default: ;
        endcase
    end

    // R8: source held off during pad and FCS bytes.
    assert_tail_blocks_input_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_DATA) |-> !s_ready);

    // R11: a stalled tail byte is held.
    assert_tail_holds_R11: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_DATA && m_valid && !m_ready) |=>
            (m_valid && $stable(m_data) && $stable(m_last)));

    // R9: the byte marked last ends the frame.
    assert_last_returns_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (m_valid && m_ready && m_last) |=> (state_q == ST_DATA && cnt == '0 && fcs_idx_q == 2'd0));

    // R2: the pad stops after the byte that reaches the pad target, FCS starts at byte 0.
    assert_pad_reaches_target_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PAD && m_ready && cnt == PAD_LAST_IDX) |=>
            (state_q == ST_FCS && fcs_idx_q == 2'd0));

    // R3: the pad state is never left for anything but the FCS.
    assert_pad_forces_fcs_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PAD) |=> (state_q == ST_PAD || state_q == ST_FCS));

endmodule

// File: tb/sim_tx_frame_finisher.sv
`timescale 1ns/1ps
module sim_tx_frame_finisher;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       s_valid = 1'b0, s_first = 1'b0, s_last = 1'b0;
    logic [7:0] s_data = 8'h00;
    logic       cfg_no_fcs = 1'b0, cfg_no_pad = 1'b0;
    logic       m_ready = 1'b1;
    logic       s_ready, m_valid, m_last;
    logic [7:0] m_data;

    always #2 clk = ~clk;

    tx_frame_finisher u0 (
        .clk(clk), .rst(rst),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .s_first(s_first), .s_last(s_last),
        .cfg_no_fcs(cfg_no_fcs), .cfg_no_pad(cfg_no_pad),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last)
    );

    int nvec = 0, nerr = 0;
    logic [7:0] pay [0:127];
    logic [7:0] expd [0:255];
    logic [7:0] got [0:255];
    int  exp_len, got_len, in_len, last_count, tail_rdy_err, hold_err;
    bit  done, bp_mode = 1'b0, prev_stall = 1'b0;
    logic [7:0] prev_data;
    int  bp_ctr = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_bits(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r = c;
        for (int k = 0; k < 8; k++) begin
            logic fb;
            fb = r[0] ^ b[k];
            r  = r >> 1;
            if (fb) r = r ^ 32'hEDB88320;
        end
        return r;
    endfunction

    // Sink back-pressure pattern.
    always @(posedge clk) begin
        #1;
        if (bp_mode) begin
            bp_ctr++;
            m_ready = (bp_ctr % 3) != 0;
        end else begin
            m_ready = 1'b1;
        end
    end

    // Output monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_stall && m_data != prev_data) hold_err++;
            prev_stall = m_valid && !m_ready && (got_len >= in_len);
            prev_data  = m_data;
            if (m_valid && m_ready) begin
                if (got_len < 256) got[got_len] = m_data;
                if (got_len >= in_len && s_ready) tail_rdy_err++;
                got_len++;
                if (m_last) begin
                    last_count++;
                    done = 1'b1;
                end
            end
        end
    end

    task automatic run_frame(input string req, input int len, input bit nf, input bit np,
                             input bit flip, input bit bp, input int seed);
        logic [31:0] c;
        bit pad, fcs;
        int firstbad;
        for (int i = 0; i < len; i++) pay[i] = 8'((i * 37 + seed * 11 + 5) & 255);
        pad = !np && (len < 60);
        fcs = pad || !nf;
        exp_len = 0;
        for (int i = 0; i < len; i++) begin expd[exp_len] = pay[i]; exp_len++; end
        if (pad) while (exp_len < 60) begin expd[exp_len] = 8'h00; exp_len++; end
        if (fcs) begin
            c = 32'hFFFFFFFF;
            for (int i = 0; i < exp_len; i++) c = crc_bits(c, expd[i]);
            c = ~c;
            for (int k = 0; k < 4; k++) begin expd[exp_len] = c[8*k +: 8]; exp_len++; end
        end
        got_len = 0; done = 1'b0; last_count = 0; tail_rdy_err = 0; hold_err = 0;
        prev_stall = 1'b0; in_len = len; bp_mode = bp;
        for (int i = 0; i < len; i++) begin
            bit taken;
            s_valid = 1'b1; s_data = pay[i];
            s_first = (i == 0); s_last = (i == len - 1);
            cfg_no_fcs = (i == 0) ? nf : (flip ? ~nf : nf);
            cfg_no_pad = (i == 0) ? np : (flip ? ~np : np);
            taken = 1'b0;
            while (!taken) begin
                @(negedge clk);
                taken = s_ready;
                @(posedge clk); #1;
            end
        end
        s_valid = 1'b0; s_first = 1'b0; s_last = 1'b0;
        for (int w = 0; w < 3000 && !done; w++) @(posedge clk);
        #1;
        bp_mode = 1'b0;
        check(got_len == exp_len, req, "frame length", got_len, exp_len);
        firstbad = -1;
        for (int i = 0; i < exp_len && i < got_len; i++)
            if (firstbad < 0 && got[i] !== expd[i]) firstbad = i;
        if (firstbad < 0) check(1'b1, req, "bytes", 0, 0);
        else check(1'b0, req, $sformatf("byte %0d", firstbad), got[firstbad], expd[firstbad]);
        check(last_count == 1, "R9", "last markers", last_count, 1);
        check(tail_rdy_err == 0, "R8", "s_ready during tail", tail_rdy_err, 0);
        if (bp) check(hold_err == 0, "R11", "stalled tail changes", hold_err, 0);
        @(posedge clk); #1;
    endtask

    task automatic t_reset_R10;
        @(negedge clk);
        check(m_valid == 1'b0, "R10", "m_valid after reset", m_valid, 0);
        check(s_ready == m_ready, "R10", "s_ready follows m_ready", s_ready, m_ready);
    endtask

    task automatic t_crc_ref_R7;
        logic [31:0] c = 32'hFFFFFFFF;
        string s = "123456789";
        for (int i = 0; i < 9; i++) c = crc_bits(c, s[i]);
        check(~c == 32'hCBF43926, "R7", "reference CRC", ~c, 32'hCBF43926);
    endtask

    task automatic t_short_default_R2;  run_frame("R2", 10, 0, 0, 0, 0, 1); endtask
    task automatic t_forced_fcs_R3;     run_frame("R3", 10, 1, 0, 0, 0, 2); endtask
    task automatic t_no_pad_R5;         run_frame("R5", 10, 0, 1, 0, 0, 3); endtask
    task automatic t_raw_short_R4;      run_frame("R4", 10, 1, 1, 0, 0, 4); endtask
    task automatic t_raw_long_R4;       run_frame("R4", 70, 1, 0, 0, 0, 5); endtask
    task automatic t_exact_min_R2;      run_frame("R2", 60, 0, 0, 0, 0, 6); endtask
    task automatic t_one_short_R2;      run_frame("R2", 59, 0, 0, 0, 0, 7); endtask
    task automatic t_late_set_R6;       run_frame("R6", 10, 0, 0, 1, 0, 8); endtask
    task automatic t_late_clear_R6;     run_frame("R6", 10, 1, 1, 1, 0, 9); endtask
    task automatic t_single_bp_R11;     run_frame("R11", 1, 0, 0, 0, 1, 10); endtask
    task automatic t_long_bp_R1;        run_frame("R1", 75, 0, 0, 0, 1, 11); endtask
    task automatic t_long_fcs_R7;       run_frame("R7", 64, 0, 1, 0, 0, 12); endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        t_reset_R10();
        @(posedge clk); #1;
        t_crc_ref_R7();
        t_short_default_R2();
        t_forced_fcs_R3();
        t_no_pad_R5();
        t_raw_short_R4();
        t_raw_long_R4();
        t_exact_min_R2();
        t_one_short_R2();
        t_late_set_R6();
        t_late_clear_R6();
        t_single_bp_R11();
        t_long_bp_R1();
        t_long_fcs_R7();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        #(4 * 150000);
        nvec++; nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule